// File: doc/BRIEF.md
# Tick-Driven Countdown Timer with Interrupt

This block is a countdown timer that host software programs through a small register port. A single 32-bit control word carries the starting count in its low 20 bits together with three control bits: one that lets the count run, one that allows an interrupt when the count expires, and one that acknowledges a pending interrupt. While running, the count drops by one on each cycle in which the external tick-enable input is high. The tick comes from a prescaler outside the block.

When the count steps from one to zero with interrupts allowed, the timer latches a pending interrupt. The pending flag drives the interrupt output and is also reported in one bit of a shared interrupt status word that other interrupt sources also use. Once at zero the counter stops and stays there until software writes a new control word. Software clears the interrupt by writing the control word with the acknowledge bit set.

Top module: `tick_countdown_timer`

## Requirements
- R1: While reset is high, and on the first cycle after it, the count, both enable bits and the pending interrupt are zero, so the control word and the status word both read as zero and irq_o is low.
- R2: A write to offset 0x60 loads write-data bits 19:0 as the count, bit 24 as the count enable and bit 25 as the interrupt enable. From the next cycle a read of offset 0x60 returns the count in bits 19:0, the count enable in bit 24 and the interrupt enable in bit 25, with every other bit zero (bit 26 always reads zero).
- R3: When the count enable is set, tick_en is high and the count is nonzero, the count drops by exactly one at that clock edge. With tick_en low or the count enable clear, the count holds.
- R4: A count of zero stays at zero on every tick until a new control word is written.
- R5: The pending interrupt is set only at the edge where the count steps from 1 to 0 while the interrupt enable is set. It is not set when the interrupt enable is clear, and it is not set again while the count stays at zero.
- R6: A control-word write with bit 26 set clears the pending interrupt.
- R7: If an acknowledging write and a 1-to-0 step of the old count happen at the same edge, the interrupt stays pending.
- R8: A read of offset 0x64 returns the pending interrupt in bit 5 and zero in all other bits. irq_o equals the pending interrupt.
- R9: A control-word write while the timer runs replaces the count at once. A tick at the same edge does not decrement the newly loaded value.
- R10: Writes to any offset other than 0x60, including the status offset 0x64, change neither the count, the enables nor the pending interrupt.
- R11: Reads of offsets other than 0x60 and 0x64 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 8 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Byte offset of the read |
| rd_data | output | 32 | Read data, combinational from rd_addr and current state |
| tick_en | input | 1 | Countdown tick, one decrement per high cycle |
| irq_o | output | 1 | Pending timer interrupt |

## Verification
The bench drives a write and an expiring tick at the same edge. A design that let the acknowledge win would drop that interrupt. A design that let the tick win would start the new count one short. The bench keeps ticking after expiry, with and without the interrupt enable and after an acknowledge, to catch a counter that wraps to all ones or an interrupt that fires again at zero. It also writes the status offset and an unmapped offset with acknowledge and enable bits set. A decoder that matched only some address bits would clear the interrupt or change the count on those writes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned ADDR_W   = 8;
    localparam int unsigned CTRL_W   = 32;
    localparam int unsigned CNT_W    = 20;
    localparam int unsigned BIT_RUN  = 24;
    localparam int unsigned BIT_IEN  = 25;
    localparam int unsigned BIT_ACK  = 26;
    localparam int unsigned IRQ_SLOT = 5;

    localparam logic [ADDR_W-1:0] OFS_CTRL_DEF = 8'h60;
    localparam logic [ADDR_W-1:0] OFS_STAT_DEF = 8'h64;

    typedef logic [CNT_W-1:0]  count_t;
    typedef logic [CTRL_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_STAT = 2'd2
    } reg_sel_t;

    typedef struct packed {
        logic   load;
        count_t value;
        logic   run;
        logic   ien;
        logic   ack;
    } ctrl_cmd_t;

    typedef struct packed {
        count_t count;
        logic   run;
        logic   ien;
    } timer_state_t;

    function automatic reg_sel_t decode_sel(input addr_t a, input addr_t ctrl_ofs,
                                            input addr_t stat_ofs);
        if (a == ctrl_ofs)      return SEL_CTRL;
        else if (a == stat_ofs) return SEL_STAT;
        else                    return SEL_NONE;
    endfunction

    function automatic ctrl_cmd_t unpack_ctrl(input logic strobe, input word_t w);
        ctrl_cmd_t c;
        c.load  = strobe;
        c.value = w[CNT_W-1:0];
        c.run   = w[BIT_RUN];
        c.ien   = w[BIT_IEN];
        c.ack   = w[BIT_ACK];
        return c;
    endfunction

    function automatic word_t pack_ctrl(input timer_state_t s);
        word_t w;
        w              = '0;
        w[CNT_W-1:0]   = s.count;
        w[BIT_RUN]     = s.run;
        w[BIT_IEN]     = s.ien;
        return w;
    endfunction

    function automatic word_t pack_status(input logic pending);
        word_t w;
        w           = '0;
        w[IRQ_SLOT] = pending;
        return w;
    endfunction

endpackage

// File: rtl/tmr_regif.sv
module tmr_regif
    import tmr_pkg::*;
#(
    parameter addr_t CTRL_OFS = OFS_CTRL_DEF,
    parameter addr_t STAT_OFS = OFS_STAT_DEF
) (
    input  logic         wr_en,
    input  addr_t        wr_addr,
    input  word_t        wr_data,
    input  addr_t        rd_addr,
    input  timer_state_t state,
    input  logic         pending,
    output ctrl_cmd_t    cmd,
    output word_t        rd_data
);
    reg_sel_t wr_sel;
    reg_sel_t rd_sel;
    logic     unused_wr_bits;

    assign unused_wr_bits = ^{wr_data[CTRL_W-1:BIT_ACK+1], wr_data[BIT_RUN-1:CNT_W]};

    always_comb begin
        wr_sel = decode_sel(wr_addr, CTRL_OFS, STAT_OFS);
        cmd    = unpack_ctrl(wr_en && (wr_sel == SEL_CTRL), wr_data);
    end

    always_comb begin
        rd_sel = decode_sel(rd_addr, CTRL_OFS, STAT_OFS);
        unique case (rd_sel)
            SEL_CTRL: rd_data = pack_ctrl(state);
            SEL_STAT: rd_data = pack_status(pending);
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  ctrl_cmd_t    cmd,
    input  logic         tick_en,
    output timer_state_t state,
    output logic         expire
);
    timer_state_t state_q;
    logic         step;

    // a decrement is taken from the old state; a load in the same cycle replaces the result
    assign step   = tick_en && state_q.run && (state_q.count != '0);
    assign expire = step && (state_q.count == count_t'(1));
    assign state  = state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else if (cmd.load) begin
            state_q.count <= cmd.value;
            state_q.run   <= cmd.run;
            state_q.ien   <= cmd.ien;
        end else if (step) begin
            state_q.count <= state_q.count - count_t'(1);
        end
    end
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
    input  logic clk,
    input  logic rst,
    input  logic raise,
    input  logic clear,
    output logic pending
);
    logic pending_q;

    assign pending = pending_q;

    // a fresh expiry outranks an acknowledge in the same cycle
    always_ff @(posedge clk) begin
        if (rst)        pending_q <= 1'b0;
        else if (raise) pending_q <= 1'b1;
        else if (clear) pending_q <= 1'b0;
    end
endmodule

// File: rtl/tick_countdown_timer.sv
module tick_countdown_timer
    import tmr_pkg::*;
#(
    parameter addr_t CTRL_OFS = OFS_CTRL_DEF,
    parameter addr_t STAT_OFS = OFS_STAT_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CTRL_W-1:0] rd_data,
    input  logic              tick_en,
    output logic              irq_o
);
    ctrl_cmd_t    cmd;
    timer_state_t state;
    logic         expire;
    logic         pending_q;
    count_t       count_q;

    assign count_q = state.count;

    tmr_regif #(
        .CTRL_OFS (CTRL_OFS),
        .STAT_OFS (STAT_OFS)
    ) u_regif (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .state   (state),
        .pending (pending_q),
        .cmd     (cmd),
        .rd_data (rd_data)
    );

    tmr_counter u_counter (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .tick_en (tick_en),
        .state   (state),
        .expire  (expire)
    );

    tmr_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .raise   (expire && state.ien),
        .clear   (cmd.load && cmd.ack),
        .pending (pending_q)
    );

    assign irq_o = pending_q;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
#(
    parameter addr_t CTRL_OFS = OFS_CTRL_DEF,
    parameter addr_t STAT_OFS = OFS_STAT_DEF
) (
    input logic   clk,
    input logic   rst,
    input logic   wr_en,
    input addr_t  wr_addr,
    input word_t  wr_data,
    input addr_t  rd_addr,
    input word_t  rd_data,
    input logic   tick_en,
    input logic   irq_o,
    input count_t cnt
);
    logic   wr_ctrl;
    logic   run_seen;
    logic   ien_seen;
    logic   unused_chk;

    assign wr_ctrl    = wr_en && (wr_addr == CTRL_OFS);
    assign unused_chk = ^{rd_data, wr_data, STAT_OFS};

    // enables as the host last wrote them, tracked from the port side
    always_ff @(posedge clk) begin
        if (rst) begin
            run_seen <= 1'b0;
            ien_seen <= 1'b0;
        end else if (wr_ctrl) begin
            run_seen <= wr_data[BIT_RUN];
            ien_seen <= wr_data[BIT_IEN];
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (cnt == '0) && !irq_o); // R1

    AST_LOAD_TAKES_VALUE: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> cnt == $past(wr_data[CNT_W-1:0])); // R9

    AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (rst)
        (!wr_ctrl && run_seen && tick_en && cnt != '0) |=> cnt == $past(cnt) - count_t'(1)); // R3

    AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!wr_ctrl && cnt == '0) |=> cnt == '0); // R4

    AST_IRQ_ON_EXPIRY: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(cnt) == count_t'(1)); // R5

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && wr_data[BIT_ACK] && !tick_en) |=> !irq_o); // R6

    AST_EXPIRY_BEATS_ACK: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && wr_data[BIT_ACK] && tick_en && run_seen && ien_seen
         && cnt == count_t'(1)) |=> irq_o); // R7

    AST_STATUS_MIRRORS_IRQ: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == STAT_OFS) |-> rd_data[IRQ_SLOT] == irq_o); // R8

    AST_OTHER_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != CTRL_OFS && !tick_en) |=> $stable(cnt) && $stable(irq_o)); // R10
endmodule

bind tick_countdown_timer tmr_checker #(
    .CTRL_OFS (CTRL_OFS),
    .STAT_OFS (STAT_OFS)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .tick_en (tick_en),
    .irq_o   (irq_o),
    .cnt     (count_q)
);

// File: tb/tick_countdown_timer_tb.sv
module tick_countdown_timer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 19;

    typedef struct packed {
        logic [3:0]  req;
        logic        wr;
        logic [7:0]  wa;
        logic [31:0] wd;
        logic        tk;
        logic [7:0]  ra;
        logic [31:0] er;
        logic        ei;
    } vec_t;

    // req, wr, wr_addr, wr_data, tick, rd_addr, expected rd_data, expected irq
    localparam vec_t VECS [NVEC] = '{
        '{4'd2,  1'b1, 8'h60, 32'h0300_0003, 1'b0, 8'h60, 32'h0300_0003, 1'b0}, // R2 load 3, both enables
        '{4'd3,  1'b0, 8'h00, 32'h0,         1'b1, 8'h60, 32'h0300_0002, 1'b0}, // R3 tick
        '{4'd3,  1'b0, 8'h00, 32'h0,         1'b0, 8'h60, 32'h0300_0002, 1'b0}, // R3 no tick holds
        '{4'd3,  1'b0, 8'h00, 32'h0,         1'b1, 8'h60, 32'h0300_0001, 1'b0}, // R3
        '{4'd5,  1'b0, 8'h00, 32'h0,         1'b1, 8'h60, 32'h0300_0000, 1'b1}, // R5 expiry
        '{4'd4,  1'b0, 8'h00, 32'h0,         1'b1, 8'h60, 32'h0300_0000, 1'b1}, // R4 holds zero
        '{4'd8,  1'b0, 8'h00, 32'h0,         1'b0, 8'h64, 32'h0000_0020, 1'b1}, // R8 status bit 5
        '{4'd6,  1'b1, 8'h60, 32'h0400_0000, 1'b0, 8'h60, 32'h0000_0000, 1'b0}, // R6 ack
        '{4'd2,  1'b1, 8'h60, 32'h0100_0002, 1'b0, 8'h60, 32'h0100_0002, 1'b0}, // R2 run only
        '{4'd3,  1'b0, 8'h00, 32'h0,         1'b1, 8'h60, 32'h0100_0001, 1'b0}, // R3
        '{4'd5,  1'b0, 8'h00, 32'h0,         1'b1, 8'h60, 32'h0100_0000, 1'b0}, // R5 no irq without enable
        '{4'd10, 1'b1, 8'h6C, 32'h0300_0055, 1'b0, 8'h60, 32'h0100_0000, 1'b0}, // R10 other offset
        '{4'd11, 1'b0, 8'h00, 32'h0,         1'b0, 8'h10, 32'h0000_0000, 1'b0}, // R11 unmapped read
        '{4'd2,  1'b1, 8'h60, 32'h0300_0001, 1'b0, 8'h60, 32'h0300_0001, 1'b0}, // R2
        '{4'd7,  1'b1, 8'h60, 32'h0700_0005, 1'b1, 8'h60, 32'h0300_0005, 1'b1}, // R7 ack vs expiry
        '{4'd9,  1'b1, 8'h60, 32'h0300_0009, 1'b1, 8'h60, 32'h0300_0009, 1'b1}, // R9 load beats tick
        '{4'd10, 1'b1, 8'h64, 32'h0400_0000, 1'b0, 8'h60, 32'h0300_0009, 1'b1}, // R10 status write
        '{4'd6,  1'b1, 8'h60, 32'h0400_0000, 1'b0, 8'h60, 32'h0000_0000, 1'b0}, // R6
        '{4'd8,  1'b0, 8'h00, 32'h0,         1'b0, 8'h64, 32'h0000_0000, 1'b0}  // R8 cleared
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [7:0]  wr_addr;
    logic [31:0] wr_data;
    logic [7:0]  rd_addr;
    logic [31:0] rd_data;
    logic        tick_en;
    logic        irq_o;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tick_countdown_timer u_dut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .tick_en (tick_en),
        .irq_o   (irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at the falling edge, sample two time units after the rising edge
    task automatic cycle(input logic wr, input logic [7:0] wa, input logic [31:0] wd,
                         input logic tk, input logic [7:0] ra);
        @(negedge clk);
        wr_en   = wr;
        wr_addr = wa;
        wr_data = wd;
        tick_en = tk;
        rd_addr = ra;
        @(posedge clk);
        #2;
    endtask

    task automatic idle_inputs();
        wr_en   = 1'b0;
        wr_addr = '0;
        wr_data = '0;
        tick_en = 1'b0;
    endtask

    initial begin
        rst = 1'b1;
        idle_inputs();
        rd_addr = 8'h60;
        repeat (3) @(posedge clk);
        #2;
        check("R1 ctrl in reset", rd_data, 32'h0);
        check("R1 irq in reset", {31'h0, irq_o}, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            cycle(VECS[i].wr, VECS[i].wa, VECS[i].wd, VECS[i].tk, VECS[i].ra);
            check($sformatf("R%0d vec%0d rd_data", VECS[i].req, i), rd_data, VECS[i].er);
            check($sformatf("R%0d vec%0d irq", VECS[i].req, i), {31'h0, irq_o}, {31'h0, VECS[i].ei});
            idle_inputs();
        end

        // R4 R5: loaded at zero with everything enabled, ticks neither wrap nor interrupt
        cycle(1'b1, 8'h60, 32'h0300_0000, 1'b0, 8'h60);
        idle_inputs();
        for (int k = 0; k < 3; k++) begin
            cycle(1'b0, 8'h00, 32'h0, 1'b1, 8'h60);
            idle_inputs();
        end
        check("R4 zero load stays zero", rd_data, 32'h0300_0000);
        check("R5 no irq from zero load", {31'h0, irq_o}, 32'h0);

        // R1: reset while an interrupt is pending
        cycle(1'b1, 8'h60, 32'h0300_0001, 1'b0, 8'h60);
        idle_inputs();
        cycle(1'b0, 8'h00, 32'h0, 1'b1, 8'h64);
        idle_inputs();
        check("R5 short expiry status", rd_data, 32'h0000_0020);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #2;
        check("R1 status after reset", rd_data, 32'h0);
        check("R1 irq after reset", {31'h0, irq_o}, 32'h0);
        rd_addr = 8'h60;
        #1;
        check("R1 ctrl after reset", rd_data, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule